// File: doc/BRIEF.md
# Weighted Two-Operand Thermometer Adder

This block adds two small unsigned binary operands and presents the total as a thermometer code. In each operand the low bit is worth one and the next bit is worth two. The output has one bit per possible unit of the total. Its ones start at bit 0 and fill upward, so the number of set bits is the sum.

The arithmetic is combinational. A sampling register on the output gives a clean one-cycle path, so the block can sit between flops in a timing test. The operand width is a parameter, and the output width is derived from it. The default is two-bit operands and a six-bit code covering totals 0 to 6.

Top module: `wbin_therm_adder`

## Requirements
- R1: One rising clock edge after inputs are applied, the number of set output bits equals opa + opb. In each operand, bit 0 weighs 1 and bit 1 weighs 2.
- R2: The set bits of the output are always contiguous from bit 0. No clear bit lies below a set bit.
- R3: Output bit k is set exactly when the registered total is at least k+1, for every k from 0 to 5.
- R4: With opa = 2'b10 and opb = 2'b01, the output after the next edge is 6'b000111.
- R5: Both operands zero gives 6'b000000. Both operands 2'b11 gives 6'b111111.
- R6: Changing the inputs between clock edges does not change the output. The output changes only at a rising edge, and it reflects the inputs sampled at that edge.
- R7: While rst is high at a rising edge, the output is cleared to all zeros at that edge, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | 2 | First operand, bit 1 weighs 2, bit 0 weighs 1 |
| opb | input | 2 | Second operand, same weighting |
| therm | output | 6 | Registered thermometer code of opa + opb |

## Verification
All sixteen operand pairs are applied in order. Each total from 0 to 6 is reached, and pairs that share a total, such as 2+1 and 1+2, must give identical codes. This separates true weighted addition from a bitwise merge of the operands. A seeded random stream then applies back-to-back changes, which exposes any latency or stale-register fault. Directed cases cover the stated 2+1 example, the all-zero and all-one extremes, inputs that change away from the clock edge, and a reset asserted while nonzero operands are present.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  // Largest value one operand can hold, doubled, gives the number of output bits.
  function automatic int therm_width(input int opw);
    return 2 * ((1 << opw) - 1);
  endfunction

  function automatic int sum_width(input int opw);
    return $clog2(therm_width(opw) + 1);
  endfunction
endpackage

// File: rtl/wsum_calc.sv
module wsum_calc #(
  parameter int OPW  = 2,
  parameter int SUMW = 3
) (
  input  logic [OPW-1:0]  opa,
  input  logic [OPW-1:0]  opb,
  output logic [SUMW-1:0] total
);
  // Binary positions already carry weights 1, 2, ...; a plain add combines them.
  assign total = SUMW'(opa) + SUMW'(opb);
endmodule

// File: rtl/thermo_expand.sv
module thermo_expand #(
  parameter int SUMW = 3,
  parameter int OUTW = 6
) (
  input  logic [SUMW-1:0] total,
  output logic [OUTW-1:0] code
);
  for (genvar k = 0; k < OUTW; k++) begin : g_level
    assign code[k] = (total > SUMW'(k));
  end
endmodule

// File: rtl/wbin_therm_adder.sv
module wbin_therm_adder #(
  parameter int OPW = 2,
  localparam int OUTW = thermo_pkg::therm_width(OPW),
  localparam int SUMW = thermo_pkg::sum_width(OPW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OPW-1:0]  opa,
  input  logic [OPW-1:0]  opb,
  output logic [OUTW-1:0] therm
);
  logic [SUMW-1:0] total;
  logic [OUTW-1:0] code_d;

  wsum_calc #(.OPW(OPW), .SUMW(SUMW)) u_sum (
    .opa(opa), .opb(opb), .total(total)
  );

  thermo_expand #(.SUMW(SUMW), .OUTW(OUTW)) u_exp (
    .total(total), .code(code_d)
  );

  always_ff @(posedge clk) begin
    if (rst) therm <= '0;
    else     therm <= code_d;
  end
endmodule

// File: rtl/wbin_therm_adder_chk.sv
module wbin_therm_adder_chk #(
  parameter int OPW = 2,
  parameter int OUTW = 6
) (
  input logic            clk,
  input logic            rst,
  input logic [OPW-1:0]  opa,
  input logic [OPW-1:0]  opb,
  input logic [OUTW-1:0] therm
);
  logic loaded;
  always_ff @(posedge clk) loaded <= !rst;

  // R1
  popcount_chk: assert property (@(posedge clk) disable iff (rst)
    loaded |-> ($countones(therm) == (int'($past(opa)) + int'($past(opb)))));

  // R2
  contiguous_chk: assert property (@(posedge clk) disable iff (rst)
    ((therm & (therm + OUTW'(1))) == '0));

  // R4
  example_chk: assert property (@(posedge clk) disable iff (rst)
    (loaded && $past(opa) == OPW'(2) && $past(opb) == OPW'(1)) |-> (therm == OUTW'(7)));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (therm == '0));
endmodule

bind wbin_therm_adder wbin_therm_adder_chk #(.OPW(OPW), .OUTW(OUTW)) u_chk (
  .clk(clk), .rst(rst), .opa(opa), .opb(opb), .therm(therm)
);

// File: tb/wbin_therm_adder_test.sv
module wbin_therm_adder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] opa = '0;
  logic [1:0] opb = '0;
  logic [5:0] therm;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wbin_therm_adder uut (.clk(clk), .rst(rst), .opa(opa), .opb(opb), .therm(therm));

  function automatic logic [5:0] expect_code(input logic [1:0] a, input logic [1:0] b);
    int s;
    logic [5:0] r;
    s = (a[1] ? 2 : 0) + (a[0] ? 1 : 0) + (b[1] ? 2 : 0) + (b[0] ? 1 : 0);
    r = '0;
    for (int k = 0; k < 6; k++) if (s >= k + 1) r[k] = 1'b1;
    return r;
  endfunction

  task automatic check(input string req, input logic [5:0] exp);
    checks++;
    if (therm !== exp) begin
      fails++;
      $display("FAIL %s: therm=%b expected=%b", req, therm, exp);
    end
  endtask

  task automatic apply(input logic [1:0] a, input logic [1:0] b, input string req);
    @(negedge clk);
    opa = a; opb = b;
    @(negedge clk);
    check(req, expect_code(a, b));
  endtask

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    opa = 2'b11; opb = 2'b11;
    repeat (3) @(negedge clk);
    check("R7 reset state", 6'b000000);
    rst = 1'b0;
    // R1 R3: exhaustive sweep
    for (int i = 0; i < 16; i++) apply(i[3:2], i[1:0], "R1/R3 sweep");
    // R4
    apply(2'b10, 2'b01, "R4 example");
    // R5
    apply(2'b00, 2'b00, "R5 zeros");
    apply(2'b11, 2'b11, "R5 ones");
    // R6: change inputs mid-cycle, output holds until next edge
    @(negedge clk);
    opa = 2'b00; opb = 2'b01;
    #1;
    check("R6 hold before edge", 6'b111111);
    @(negedge clk);
    check("R6 update at edge", 6'b000001);
    // R2 R1: random back-to-back
    for (int n = 0; n < 40; n++) begin
      logic [1:0] a, b;
      a = 2'($urandom);
      b = 2'($urandom);
      apply(a, b, "R1/R2 random");
    end
    // R7: reset with nonzero operands
    @(negedge clk);
    opa = 2'b11; opb = 2'b10; rst = 1'b1;
    @(negedge clk);
    check("R7 reset midrun", 6'b000000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 6'b011111);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule